// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches the already-synchronized levels of a bank of general-purpose input lines and turns selected activity on each line into an interrupt request. Each line has its own 3-bit event selector, which picks one of five trigger conditions. The choices are a falling edge, a rising edge, either edge, a held low level or a held high level. Every detected event sets that line's bit in a status register. Reading the status register clears it.

A mask register decides which status bits reach the bank's single interrupt output. Software never writes the mask directly. It writes ones to one offset to enable lines and ones to another offset to disable them, so lines it does not name keep their mask state. An interrupt handler reads the status repeatedly until the masked result is zero. For this reason, an event that arrives in the same cycle as a clearing read is kept for the next read and is never dropped.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset the status and mask registers are zero, the read data is zero and `irq` is low.
- R2: Selector code 0 flags a 1-to-0 change of the line, code 1 flags a 0-to-1 change, and code 2 flags either change. Edges are found by comparing the line with its level in the previous cycle. No edge is reported in the first cycle after reset, whatever level the line held during reset.
- R3: Selector code 3 sets the line's status bit in every cycle the line is low. Code 4 does the same in every cycle the line is high. While the level holds, the bit reappears right after a clearing read.
- R4: Selector codes 5, 6 and 7 never set a status bit.
- R5: A status bit is set by its event whether the line's mask bit is set or not.
- R6: A write to offset 0x20 sets the mask bits where the write data has ones. A write to offset 0x24 clears the mask bits where the write data has ones. Zero data bits leave the mask unchanged in both cases. Writes to any other offset do not change the mask. A read of offset 0x28 returns the mask.
- R7: A read of offset 0x2C returns the status as it stood before the read and clears it. Read data appears in the cycle after the read strobe. Reads of unmapped offsets return zero.
- R8: An event detected in the same cycle as a status read is still set in the status after that read.
- R9: `irq` is high exactly when some line has both its status bit and its mask bit set. It is the only interrupt output of the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_lvl | input | NLINES | Synchronized line levels |
| evt_sel | input | NLINES*3 | Per-line event selector, line i in bits [3i+2:3i] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | NLINES | Write data, one bit per line |
| bus_rdata | output | NLINES | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Bank interrupt request |

## Verification
The bench holds a line high through reset while that line has a rising-edge selector. A design that took its reset value of the previous level as a real level would report a false edge here. It also starts a rising edge in the same cycle as a status read; a design that cleared the status unconditionally on read would lose that event. A level-selected line is read twice in a row to show that its bit comes back after the clearing read, and an edge bit is read twice to show that it does not. Enable and disable writes are made with overlapping ones, and a write to the mask readback offset is made as well. These show a design that treated the mask as a plain writable register, or that applied the wrong write-one semantics.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_kind_e;

  // byte offsets inside the bank window
  localparam logic [7:0] OFS_EN   = 8'h20;
  localparam logic [7:0] OFS_DIS  = 8'h24;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_STAT = 8'h2C;

  // one line's trigger decision; prv_ok gates edges until a real history exists
  function automatic logic ev_fire(logic [SEL_W-1:0] sel, logic cur,
                                   logic prv, logic prv_ok);
    logic f;
    case (sel)
      EV_FALL: f = prv_ok & prv & ~cur;
      EV_RISE: f = prv_ok & ~prv & cur;
      EV_BOTH: f = prv_ok & (prv ^ cur);
      EV_LOW:  f = ~cur;
      EV_HIGH: f = cur;
      default: f = 1'b0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect import gpio_evt_pkg::*; #(
  parameter int NLINES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       lvl,
  input  logic [NLINES*SEL_W-1:0] sel,
  output logic [NLINES-1:0]       hit
);

  logic [NLINES-1:0] prev_q;
  logic              prev_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      prev_q    <= lvl;
      prev_ok_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [SEL_W-1:0] s;
    assign s      = sel[i*SEL_W +: SEL_W];
    assign hit[i] = ev_fire(s, lvl[i], prev_q[i], prev_ok_q);

    AST_UNDEF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (s > 3'd4) |-> !hit[i]);                                   // R4
    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (s == EV_HIGH && lvl[i]) |-> hit[i]);                      // R3
    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (s == EV_LOW && !lvl[i]) |-> hit[i]);                      // R3
    AST_NO_EDGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (s <= 3'd2 && $stable(lvl[i])) |-> !hit[i]);               // R2
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] hit,
  input  logic              en_wr,
  input  logic              dis_wr,
  input  logic              stat_rd,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] status_q,
  output logic [NLINES-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (stat_rd) begin
      status_q <= hit;               // clear, but keep this cycle's events
    end else begin
      status_q <= status_q | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (en_wr) begin
      mask_q <= mask_q | wdata;
    end else if (dis_wr) begin
      mask_q <= mask_q & ~wdata;
    end
  end

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && hit == '0) |=> (status_q == '0));                        // R7
  AST_KEEP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));            // R8
  AST_MASK_EN: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));                // R6
  AST_MASK_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && !en_wr) |=> ((mask_q & $past(wdata)) == '0));             // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !dis_wr) |=> $stable(mask_q));                            // R6

endmodule

// File: rtl/gpio_evt_rdport.sv
module gpio_evt_rdport #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              mask_rd,
  input  logic              stat_rd,
  input  logic [NLINES-1:0] status_q,
  input  logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] rdata
);

  logic [NLINES-1:0] rsel;

  always_comb begin
    if (mask_rd)      rsel = mask_q;
    else if (stat_rd) rsel = status_q;
    else              rsel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rsel;
  end

  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd |=> (rdata == $past(mask_q)));                      // R6
  AST_RD_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (rdata == $past(status_q)));                    // R7

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank import gpio_evt_pkg::*; #(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINES-1:0]       line_lvl,
  input  logic [NLINES*SEL_W-1:0] evt_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [NLINES-1:0]       bus_wdata,
  output logic [NLINES-1:0]       bus_rdata,
  output logic                    irq
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  // named decode events
  logic en_wr, dis_wr, mask_rd, stat_rd;
  assign en_wr   = bus_wr && (bus_addr == A_EN);
  assign dis_wr  = bus_wr && (bus_addr == A_DIS);
  assign mask_rd = bus_rd && (bus_addr == A_MASK);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  logic [NLINES-1:0] hit, status_q, mask_q;

  gpio_evt_detect #(.NLINES(NLINES)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (line_lvl),
    .sel   (evt_sel),
    .hit   (hit)
  );

  gpio_evt_regs #(.NLINES(NLINES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .en_wr    (en_wr),
    .dis_wr   (dis_wr),
    .stat_rd  (stat_rd),
    .wdata    (bus_wdata),
    .status_q (status_q),
    .mask_q   (mask_q)
  );

  gpio_evt_rdport #(.NLINES(NLINES)) u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (bus_rd),
    .mask_rd  (mask_rd),
    .stat_rd  (stat_rd),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rdata    (bus_rdata)
  );

  assign irq = |(status_q & mask_q);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);                                   // R9
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status_q != '0));                           // R9

endmodule

// File: tb/gpio_evt_bank_bench.sv
module gpio_evt_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam logic [7:0] AD_EN = 8'h20, AD_DIS = 8'h24, AD_MASK = 8'h28, AD_STAT = 8'h2C;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NL-1:0] line_lvl = '0;
  logic [2:0]    sel_a [NL];
  logic [NL*3-1:0] evt_sel;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [NL-1:0] bus_wdata = '0;
  logic [NL-1:0] bus_rdata;
  logic          irq;

  always_comb for (int i = 0; i < NL; i++) evt_sel[i*3 +: 3] = sel_a[i];

  gpio_evt_bank #(.NLINES(NL), .ADDR_W(8)) u_gpio_evt_bank (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .evt_sel(evt_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  int n_chk = 0, n_err = 0;
  logic [NL-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_track = 1'b0;

  task automatic check(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read data valid one cycle after the strobe
  always @(posedge clk) rd_track <= bus_rd;
  always @(negedge clk) begin
    if (rd_track) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: unexpected read result actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // driver: queue expected value, issue one read
  task automatic rd(logic [7:0] a, logic [NL-1:0] exp, string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [NL-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) sel_a[i] = 3'd7;
    sel_a[0] = 3'd1;          // rising, line held high through reset
    line_lvl[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, '0);
    rd(AD_MASK, '0, "R1 mask after reset");
    rd(AD_STAT, '0, "R2 no false edge after reset");
    sel_a[0] = 3'd7;

    // R2 edges: line1 rise, line2 fall, line3 both
    @(negedge clk);
    sel_a[1] = 3'd1; sel_a[2] = 3'd0; sel_a[3] = 3'd2;
    @(negedge clk);
    line_lvl[1] = 1'b1; line_lvl[2] = 1'b1; line_lvl[3] = 1'b1;
    @(negedge clk);
    line_lvl[2] = 1'b0; line_lvl[3] = 1'b0;
    @(negedge clk);
    check("R5 irq low with mask clear", {31'b0, irq}, '0);
    wr(AD_EN, 32'h2);
    check("R9 irq high with masked status", {31'b0, irq}, 32'h1);
    rd(AD_MASK, 32'h2, "R6 mask after enable");
    rd(AD_STAT, 32'h0000_000E, "R2 edge status");
    check("R9 irq low after clearing read", {31'b0, irq}, '0);
    rd(AD_STAT, '0, "R7 status cleared by read");
    line_lvl[1] = 1'b0;       // falling on rise-only line
    @(negedge clk);
    rd(AD_STAT, '0, "R2 falling ignored by rising selector");

    // R6 enable/disable with overlap, writes to other offsets
    wr(AD_EN, 32'h5);
    wr(AD_DIS, 32'h3);
    rd(AD_MASK, 32'h4, "R6 set then clear by ones");
    wr(AD_MASK, 32'hFFFF_FFFF);
    rd(AD_MASK, 32'h4, "R6 write to readback offset ignored");
    rd(8'h30, '0, "R7 unmapped offset reads zero");
    wr(AD_DIS, 32'hFFFF_FFFF);
    rd(AD_MASK, '0, "R6 disable all");

    // R3 high level re-asserts; mask on keeps irq up
    wr(AD_EN, 32'h10);
    sel_a[4] = 3'd4; line_lvl[4] = 1'b1;
    @(negedge clk);
    rd(AD_STAT, 32'h10, "R3 high level first read");
    check("R3 irq re-asserted after read", {31'b0, irq}, 32'h1);
    rd(AD_STAT, 32'h10, "R3 high level second read");
    sel_a[4] = 3'd7;
    rd(AD_STAT, 32'h10, "R3 bit held after select off");
    rd(AD_STAT, '0, "R3 cleared once level event stops");
    wr(AD_DIS, 32'h10);

    // R3 low level
    sel_a[5] = 3'd3;
    @(negedge clk);
    rd(AD_STAT, 32'h20, "R3 low level first read");
    rd(AD_STAT, 32'h20, "R3 low level second read");
    sel_a[5] = 3'd7;
    rd(AD_STAT, 32'h20, "R3 low held");
    rd(AD_STAT, '0, "R3 low cleared");

    // R4 undefined selectors
    sel_a[6] = 3'd5; sel_a[7] = 3'd6; sel_a[8] = 3'd7;
    @(negedge clk);
    line_lvl[8:6] = 3'b111;
    @(negedge clk);
    line_lvl[8:6] = 3'b000;
    @(negedge clk);
    rd(AD_STAT, '0, "R4 codes 5-7 detect nothing");

    // R8 event in the same cycle as the clearing read
    sel_a[1] = 3'd1;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AD_STAT; line_lvl[1] = 1'b1;
    exp_q.push_back('0); tag_q.push_back("R8 read during event returns old status");
    @(negedge clk);
    bus_rd = 1'b0;
    rd(AD_STAT, 32'h2, "R8 event kept after clearing read");
    rd(AD_STAT, '0, "R8 then cleared");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule